// File: doc/BRIEF.md
# Audio Sample FIFO Port

This block sits between a host register bus and the sample strobes of a serial audio link. It holds two independent queues of 24-bit sample words. The playback queue is filled by host writes to a data register and drained one word per request from the serial side. The capture queue is filled one word per strobe from the serial side and drained by host reads of a second data register. A 16-bit sample rides in bits 23:8 of each word.

Each direction has a control register and a status register. The control register holds a self-clearing flush bit and a half-level interrupt enable. The status register shows the queue fill level and two sticky error flags, which software clears by writing 1. The playback interrupt is raised while its queue is at or below half depth, which asks the host for more data. The capture interrupt is raised while its queue is at or above half depth, which asks the host to drain it.

Top module: `audio_fifo_port`

## Requirements
- R1: A host write to the playback data register (offset 0x08) queues bits 23:0 of the write data and ignores bits 31:24. Each pulse of `ser_tx_req` takes the oldest word, which appears on `ser_tx_data` one cycle later, in first-in first-out order.
- R2: Each pulse of `ser_rx_vld` queues `ser_rx_data` in the capture queue. A read of the capture data register (offset 0x18) returns the oldest word in bits 23:0, with bits 31:24 reading 0, and removes that word. A 16-bit sample placed in bits 23:8 comes back unchanged in bits 23:8.
- R3: The playback status register (offset 0x04) and the capture status register (offset 0x14) report the current fill level in bits 16:8. A host write and a serial pop in the same cycle leave the playback level unchanged.
- R4: Writing 1 to bit 0 of the playback control register (0x00) or the capture control register (0x10) empties that queue, and the level reads 0 on the next cycle. The flush takes priority over a push in the same cycle. Bit 0 always reads 0, and the error flags are not changed by a flush.
- R5: Bit 20 of a control register is a read/write interrupt enable. `irq_out` is high while the playback enable is set and the playback level is at most DEPTH/2.
- R6: `irq_in` is high while the capture enable is set and the capture level is at least DEPTH/2.
- R7: A `ser_tx_req` pulse on an empty playback queue puts zero on `ser_tx_data` and sets the playback underrun flag (status bit 0).
- R8: A `ser_rx_vld` pulse on a full capture queue drops the incoming word, leaves the level at DEPTH, and sets the capture overrun flag (status bit 4).
- R9: A host write to a full playback queue is dropped and sets the playback overrun flag (bit 4). A host read of an empty capture queue returns 0 and sets the capture underrun flag (bit 0).
- R10: The error flags stay set until a status write carries 1 in the flag's bit position. Writing 0 to that bit leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the capture queue at offset 0x18 |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| ser_tx_req | input | 1 | Serial side requests one playback word |
| ser_tx_data | output | 24 | Playback word, registered on the request |
| ser_rx_vld | input | 1 | Serial side offers one capture word |
| ser_rx_data | input | 24 | Capture word |
| irq_out | output | 1 | Playback half-level interrupt |
| irq_in | output | 1 | Capture half-level interrupt |

## Verification
Register reads are combinational, so the capture word and the status bits are valid in the same cycle as the read strobe. A capture read pops its word at the next edge. Levels, flags, interrupts and the result of a flush all change at the edge that follows the write or strobe. `ser_tx_data` also changes at the edge that takes the request. The bench drives each operation for exactly one cycle, starting at a falling edge. It samples results at the next falling edge, and samples read data before the popping edge.

// File: rtl/audio_fifo_port.sv
module audio_fifo_port #(
  parameter int DEPTH = 256,
  parameter int WW    = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ser_tx_req,
  output logic [WW-1:0] ser_tx_data,
  input  logic          ser_rx_vld,
  input  logic [WW-1:0] ser_rx_data,
  output logic          irq_out,
  output logic          irq_in
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
  localparam logic [5:0] A_OCTL = 6'h00, A_OSTA = 6'h04, A_ODAT = 6'h08;
  localparam logic [5:0] A_ICTL = 6'h10, A_ISTA = 6'h14, A_IDAT = 6'h18;
  localparam int IEN_BIT = 20;

  logic [WW-1:0] out_mem [DEPTH];
  logic [WW-1:0] in_mem  [DEPTH];
  logic [AW-1:0] out_wp, out_rp, in_wp, in_rp;
  logic [CW-1:0] out_cnt, in_cnt;
  logic out_ien, in_ien, out_ovr, out_unf, in_ovr, in_unf;

  wire sel_oc = reg_addr == A_OCTL;
  wire sel_os = reg_addr == A_OSTA;
  wire sel_od = reg_addr == A_ODAT;
  wire sel_ic = reg_addr == A_ICTL;
  wire sel_is = reg_addr == A_ISTA;
  wire sel_id = reg_addr == A_IDAT;

  wire o_clr   = reg_wr && sel_oc && reg_wdata[0];
  wire i_clr   = reg_wr && sel_ic && reg_wdata[0];
  wire o_full  = out_cnt == FULL;
  wire o_empty = out_cnt == '0;
  wire i_full  = in_cnt == FULL;
  wire i_empty = in_cnt == '0;

  wire o_wr_req = reg_wr && sel_od;
  wire i_rd_req = reg_rd && sel_id;
  wire o_push = o_wr_req && !o_full && !o_clr;
  wire o_pop  = ser_tx_req && !o_empty && !o_clr;
  wire i_push = ser_rx_vld && !i_full && !i_clr;
  wire i_pop  = i_rd_req && !i_empty && !i_clr;

  wire o_st_w1c = reg_wr && sel_os;
  wire i_st_w1c = reg_wr && sel_is;

  assign irq_out = out_ien && (out_cnt <= HALF);
  assign irq_in  = in_ien && (in_cnt >= HALF);

  wire [8:0] out_lvl = 9'(out_cnt);
  wire [8:0] in_lvl  = 9'(in_cnt);

  always_comb begin
    reg_rdata = '0;
    unique case (1'b1)
      sel_oc: reg_rdata[IEN_BIT] = out_ien;
      sel_ic: reg_rdata[IEN_BIT] = in_ien;
      sel_os: reg_rdata = {15'b0, out_lvl, 3'b0, out_ovr, 3'b0, out_unf};
      sel_is: reg_rdata = {15'b0, in_lvl, 3'b0, in_ovr, 3'b0, in_unf};
      sel_id: reg_rdata = i_empty ? '0 : 32'(in_mem[in_rp]);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (o_push) out_mem[out_wp] <= reg_wdata[WW-1:0];
    if (i_push) in_mem[in_wp]   <= ser_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
      in_wp  <= '0; in_rp  <= '0; in_cnt  <= '0;
      ser_tx_data <= '0;
    end else begin
      if (o_clr) begin
        out_wp <= '0; out_rp <= '0; out_cnt <= '0;
      end else begin
        if (o_push) out_wp <= out_wp + 1'b1;
        if (o_pop)  out_rp <= out_rp + 1'b1;
        out_cnt <= out_cnt + CW'(o_push) - CW'(o_pop);
      end
      if (i_clr) begin
        in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      end else begin
        if (i_push) in_wp <= in_wp + 1'b1;
        if (i_pop)  in_rp <= in_rp + 1'b1;
        in_cnt <= in_cnt + CW'(i_push) - CW'(i_pop);
      end
      if (ser_tx_req) ser_tx_data <= o_pop ? out_mem[out_rp] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_ien <= 1'b0; in_ien <= 1'b0;
      out_ovr <= 1'b0; out_unf <= 1'b0;
      in_ovr  <= 1'b0; in_unf  <= 1'b0;
    end else begin
      if (reg_wr && sel_oc) out_ien <= reg_wdata[IEN_BIT];
      if (reg_wr && sel_ic) in_ien  <= reg_wdata[IEN_BIT];
      if (o_wr_req && o_full && !o_clr) out_ovr <= 1'b1;
      else if (o_st_w1c && reg_wdata[4]) out_ovr <= 1'b0;
      if (ser_tx_req && o_empty) out_unf <= 1'b1;
      else if (o_st_w1c && reg_wdata[0]) out_unf <= 1'b0;
      if (ser_rx_vld && i_full && !i_clr) in_ovr <= 1'b1;
      else if (i_st_w1c && reg_wdata[4]) in_ovr <= 1'b0;
      if (i_rd_req && i_empty) in_unf <= 1'b1;
      else if (i_st_w1c && reg_wdata[0]) in_unf <= 1'b0;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= FULL && in_cnt <= FULL); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_oc && reg_wdata[0]) |=> out_cnt == '0); // R4
  AST_TX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_tx_req && out_cnt == '0) |=> (ser_tx_data == '0 && out_unf)); // R7
  AST_RX_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx_vld && in_cnt == FULL && !i_rd_req && !(reg_wr && sel_ic))
    |=> (in_cnt == FULL && in_ovr)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_unf && !(reg_wr && sel_os && reg_wdata[0])) |=> out_unf); // R10
endmodule

// File: tb/audio_fifo_port_tb.sv
module audio_fifo_port_tb;
  localparam int DEPTH = 256;
  localparam logic [5:0] OCTL = 6'h00, OSTA = 6'h04, ODAT = 6'h08;
  localparam logic [5:0] ICTL = 6'h10, ISTA = 6'h14, IDAT = 6'h18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ser_tx_req = 1'b0, ser_rx_vld = 1'b0;
  logic [23:0] ser_tx_data, ser_rx_data = '0;
  logic irq_out, irq_in;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  audio_fifo_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_tx_req(ser_tx_req), .ser_tx_data(ser_tx_data),
    .ser_rx_vld(ser_rx_vld), .ser_rx_data(ser_rx_data),
    .irq_out(irq_out), .irq_in(irq_in)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic pull(output logic [23:0] d);
    ser_tx_req = 1'b1;
    step();
    ser_tx_req = 1'b0;
    d = ser_tx_data;
  endtask

  task automatic push_rx(logic [23:0] d);
    ser_rx_vld = 1'b1; ser_rx_data = d;
    step();
    ser_rx_vld = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(OSTA, v); chk("R3 reset out status", v, 0);
    rd(ISTA, v); chk("R3 reset in status", v, 0);
    rd(OCTL, v); chk("R5 reset out ctrl", v, 0);
    chk("R5 reset irqs", {irq_out, irq_in}, 0);
    chk("R1 reset tx data", 32'(ser_tx_data), 0);
  endtask

  task automatic t_tx_order();
    logic [31:0] v; logic [23:0] d;
    wr(ODAT, 32'hFF123456); wr(ODAT, 32'h0000ABCD); wr(ODAT, 32'h5AFEDCBA);
    rd(OSTA, v); chk("R3 out level 3", v, 32'd3 << 8);
    pull(d); chk("R1 first word, upper bits ignored", 32'(d), 32'h123456);
    pull(d); chk("R1 second word", 32'(d), 32'h00ABCD);
    pull(d); chk("R1 third word", 32'(d), 32'hFEDCBA);
    rd(OSTA, v); chk("R3 out level 0", v, 0);
  endtask

  task automatic t_rx_order();
    logic [31:0] v;
    push_rx({16'hBEEF, 8'h00}); push_rx(24'h13579B);
    rd(ISTA, v); chk("R3 in level 2", v, 32'd2 << 8);
    rd(IDAT, v); chk("R2 16-bit sample in 23:8", v, 32'h00BEEF00);
    rd(IDAT, v); chk("R2 second word", v, 32'h0013579B);
    rd(ISTA, v); chk("R3 in level after reads", v, 0);
  endtask

  task automatic t_underrun();
    logic [31:0] v; logic [23:0] d;
    pull(d); chk("R7 empty pull sends zero", 32'(d), 0);
    rd(OSTA, v); chk("R7 underrun flag", v, 32'h1);
    wr(OSTA, 32'h0); rd(OSTA, v); chk("R10 write 0 keeps flag", v, 32'h1);
    wr(OSTA, 32'h1); rd(OSTA, v); chk("R10 write 1 clears flag", v, 0);
  endtask

  task automatic t_out_full_and_flush();
    logic [31:0] v; logic [23:0] d;
    for (int i = 0; i < DEPTH; i++) wr(ODAT, 32'h00A00000 | i);
    wr(ODAT, 32'h00EEEEEE);
    rd(OSTA, v); chk("R9 out overrun flag, level full", v, 32'h00010010);
    pull(d); chk("R9 dropped write not queued, oldest first", 32'(d), 32'h00A00000);
    wr(OCTL, 32'h1);
    rd(OSTA, v); chk("R4 flush empties, flag kept", v, 32'h10);
    rd(OCTL, v); chk("R4 flush bit reads 0", v, 0);
    wr(OSTA, 32'h10);
    wr(ODAT, 32'h000000AA);
    pull(d); chk("R4 pointers reset after flush", 32'(d), 32'hAA);
  endtask

  task automatic t_simul();
    logic [31:0] v; logic [23:0] d;
    wr(ODAT, 32'h111111);
    reg_wr = 1'b1; reg_addr = ODAT; reg_wdata = 32'h222222; ser_tx_req = 1'b1;
    step();
    reg_wr = 1'b0; ser_tx_req = 1'b0;
    chk("R1 pop during push", 32'(ser_tx_data), 32'h111111);
    rd(OSTA, v); chk("R3 push and pop keep level", v, 32'd1 << 8);
    pull(d); chk("R1 concurrent push kept", 32'(d), 32'h222222);
  endtask

  task automatic t_irq_out();
    logic [23:0] d;
    chk("R5 disabled irq_out low", 32'(irq_out), 0);
    wr(OCTL, 32'h1 << 20);
    chk("R5 irq_out at level 0", 32'(irq_out), 1);
    for (int i = 0; i < DEPTH / 2; i++) wr(ODAT, i);
    chk("R5 irq_out at half", 32'(irq_out), 1);
    wr(ODAT, 32'h5);
    chk("R5 irq_out above half", 32'(irq_out), 0);
    pull(d);
    chk("R5 irq_out back at half", 32'(irq_out), 1);
    wr(OCTL, 32'h1);
    chk("R5 enable bit cleared by write", 32'(irq_out), 0);
  endtask

  task automatic t_irq_in_overrun();
    logic [31:0] v; int bad;
    wr(ICTL, 32'h1 << 20);
    for (int i = 0; i < DEPTH / 2 - 1; i++) push_rx(24'(i));
    chk("R6 irq_in below half", 32'(irq_in), 0);
    push_rx(24'(DEPTH / 2 - 1));
    chk("R6 irq_in at half", 32'(irq_in), 1);
    for (int i = DEPTH / 2; i < DEPTH; i++) push_rx(24'(i));
    push_rx(24'hFFFFFF);
    rd(ISTA, v); chk("R8 overrun flag, level full", v, 32'h00010010);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(IDAT, v);
      if (v != 32'(i)) bad++;
    end
    chk("R8 queued words intact, extra dropped", bad, 0);
    rd(IDAT, v); chk("R9 empty read returns 0", v, 0);
    rd(ISTA, v); chk("R9 capture underrun flag", v, 32'h11);
    wr(ISTA, 32'h11); rd(ISTA, v); chk("R10 flags cleared", v, 0);
  endtask

  task automatic t_flush_beats_push();
    logic [31:0] v;
    push_rx(24'h1); push_rx(24'h2); push_rx(24'h3);
    ser_rx_vld = 1'b1; ser_rx_data = 24'h4;
    reg_wr = 1'b1; reg_addr = ICTL; reg_wdata = 32'h1;
    step();
    ser_rx_vld = 1'b0; reg_wr = 1'b0;
    rd(ISTA, v); chk("R4 flush wins over push", v, 0);
    push_rx(24'h77);
    rd(IDAT, v); chk("R4 capture pointers reset", v, 32'h77);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_rx_order();
    t_underrun();
    t_out_full_and_flush();
    t_simul();
    t_irq_out();
    t_irq_in_overrun();
    t_flush_beats_push();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule